// File: doc/BRIEF.md
# Bridge Control Register File

This block is the control register bank of a host bridge. It holds twenty-eight 32-bit word registers covering power-on and general configuration, address-map setup, GPIO data and enables, interrupt steering, edge and polarity selection, four mailboxes, cache control and timing. Software reaches it through a simple word-wide port: a write strobe with data, a read strobe, and a byte offset whose two low bits are ignored.

Most registers simply store what is written. The interrupt enable word is the exception. It cannot be written directly. It is changed only through a set alias and a clear alias, which update it one bit at a time. The interrupt status word is also read-only. A rising edge on one bit of the general configuration register produces a single-cycle system reset request. The enable, edge-select and polarity words are driven continuously to the interrupt router.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset, the registers hold these values, listed by byte offset: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other register holds 0. sys_reset_req is 0 after reset.
- R2: The register index is addr[6:2], and addr[1:0] is ignored. A write to any of the plain offsets (0x00, 0x08 to 0x2C, 0x40 to 0x6C) stores the full 32-bit word. A read with rd_en returns the stored word on rdata in the cycle after the request, and rdata holds that value until the next read.
- R3: A write to offset 0x30 stores the data there and ORs it into the enable word at 0x38.
- R4: A write to offset 0x34 stores the data there and clears in the enable word at 0x38 every bit that is 1 in the data.
- R5: Direct writes to 0x38 (enable) and 0x3C (status) change nothing. The status word reads 0.
- R6: A write to 0x04 always stores the data. If bit 2 of the stored value was 0 and bit 2 of the new data is 1, sys_reset_req is 1 for exactly the one cycle after the write. In every other case it stays 0.
- R7: Writes to offsets 0x70 to 0x7C are ignored, and reads there return 0.
- R8: irq_enable, irq_edge and irq_polarity always equal the registers at 0x38, 0x24 and 0x2C.
- R9: When a read and a write occur in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| addr | input | 7 | Byte offset; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| irq_enable | output | 32 | Current interrupt enable word |
| irq_edge | output | 32 | Edge-select word |
| irq_polarity | output | 32 | Polarity word |

## Verification
The hardest state to reach is the exact history behind a reset request. A pulse needs bit 2 of the general configuration register to be 0 first, and it resets to 1. The bench therefore clears the bit, raises it, and then rewrites it while it is already set, predicting the pulse for every write from its own model of the old value. The enable word can only be reached through its two aliases, so the bench alternates set and clear patterns that overlap. It compares irq_enable after each one, and it also fires direct writes at the enable offset that must leave the word unchanged.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int DATA_W       = 32;
    localparam int NUM_REGS     = 28;
    localparam int IDX_W        = 5;
    localparam int ADDR_W       = IDX_W + 2;
    localparam int IX_GENCFG    = 1;
    localparam int IX_EDGE      = 9;
    localparam int IX_POL       = 11;
    localparam int IX_ENSET     = 12;
    localparam int IX_ENCLR     = 13;
    localparam int IX_EN        = 14;
    localparam int IX_STAT      = 15;
    localparam int RST_TRIG_BIT = 2;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_PLAIN,
        WK_GENCFG,
        WK_SET,
        WK_CLR
    } wkind_e;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

    typedef struct packed {
        bank_t             regs;
        logic [DATA_W-1:0] rdata;
        logic              rst_req;
    } state_t;

    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

    function automatic bank_t reset_bank();
        bank_t b;
        for (int k = 0; k < NUM_REGS; k++) begin
            b[k] = reset_word(k);
        end
        return b;
    endfunction
endpackage

// File: rtl/brc_decode.sv
module brc_decode
    import brc_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output wkind_e           kind
);
    always_comb begin
        if (idx == IDX_W'(IX_GENCFG)) begin
            kind = WK_GENCFG;
        end else if (idx == IDX_W'(IX_ENSET)) begin
            kind = WK_SET;
        end else if (idx == IDX_W'(IX_ENCLR)) begin
            kind = WK_CLR;
        end else if (idx == IDX_W'(IX_EN) || idx == IDX_W'(IX_STAT)) begin
            kind = WK_NONE;
        end else if (idx < IDX_W'(NUM_REGS)) begin
            kind = WK_PLAIN;
        end else begin
            kind = WK_NONE;
        end
    end
endmodule

// File: rtl/brc_readmux.sv
module brc_readmux
    import brc_pkg::*;
(
    input  bank_t             regs,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    logic [NUM_REGS-1:0][DATA_W-1:0] masked;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign masked[g] = (idx == IDX_W'(g)) ? regs[g] : '0;
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            word = word | masked[k];
        end
    end
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
    import brc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sys_reset_req,
    output logic [DATA_W-1:0] irq_enable,
    output logic [DATA_W-1:0] irq_edge,
    output logic [DATA_W-1:0] irq_polarity
);
    state_t            s_d, s_q;
    logic [IDX_W-1:0]  idx;
    wkind_e            kind;
    logic [DATA_W-1:0] rd_word;
    logic [1:0]        unused_lo;

    assign idx       = addr[ADDR_W-1:2];
    assign unused_lo = addr[1:0];

    brc_decode u_dec (
        .idx  (idx),
        .kind (kind)
    );

    brc_readmux u_rmux (
        .regs (s_q.regs),
        .idx  (idx),
        .word (rd_word)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rst_req = 1'b0;
        if (rd_en) begin
            s_d.rdata = rd_word;
        end
        if (wr_en) begin
            case (kind)
                WK_PLAIN: begin
                    for (int k = 0; k < NUM_REGS; k++) begin
                        if (idx == IDX_W'(k)) begin
                            s_d.regs[k] = wdata;
                        end
                    end
                end
                WK_GENCFG: begin
                    s_d.rst_req = !s_q.regs[IX_GENCFG][RST_TRIG_BIT]
                                  && wdata[RST_TRIG_BIT];
                    s_d.regs[IX_GENCFG] = wdata;
                end
                WK_SET: begin
                    s_d.regs[IX_ENSET] = wdata;
                    s_d.regs[IX_EN]    = s_q.regs[IX_EN] | wdata;
                end
                WK_CLR: begin
                    s_d.regs[IX_ENCLR] = wdata;
                    s_d.regs[IX_EN]    = s_q.regs[IX_EN] & ~wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.regs    <= reset_bank();
            s_q.rdata   <= '0;
            s_q.rst_req <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata         = s_q.rdata;
    assign sys_reset_req = s_q.rst_req;
    assign irq_enable    = s_q.regs[IX_EN];
    assign irq_edge      = s_q.regs[IX_EDGE];
    assign irq_polarity  = s_q.regs[IX_POL];

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_SET) |=> ((irq_enable & $past(wdata)) == $past(wdata)));

    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_CLR) |=> ((irq_enable & $past(wdata)) == '0));

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (kind == WK_SET || kind == WK_CLR)) |=> $stable(irq_enable));

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    // R6
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == WK_GENCFG && wdata[RST_TRIG_BIT]
         && !s_q.regs[IX_GENCFG][RST_TRIG_BIT]) |=> sys_reset_req);

    // R7
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx >= IDX_W'(NUM_REGS)) |=> (rdata == '0));
endmodule

// File: tb/sim_bridge_ctrl_regs.sv
`timescale 1ns/1ps
module sim_bridge_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sys_reset_req;
    logic [31:0] irq_enable, irq_edge, irq_polarity;

    int checks = 0;
    int errors = 0;
    logic [31:0] m [32];

    always #10 clk = ~clk;

    bridge_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_reset_req(sys_reset_req),
        .irq_enable(irq_enable), .irq_edge(irq_edge), .irq_polarity(irq_polarity)
    );

    function automatic logic [31:0] rst_val(input int i);
        case (i)
            0: return 32'hC40;        1: return 32'h1384;
            2: return 32'h2BFF8010;   3: return 32'h255E0091;
            4: return 32'h6140;       7: return 32'h1FF;
            8: return 32'h1FF;        26: return 32'h8;
            27: return 32'h10000000;  default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m[i] = rst_val(i);
    endtask

    task automatic wr(input int idx, input logic [1:0] lo, input logic [31:0] v);
        logic exp_p;
        exp_p = (idx == 1) && !m[1][2] && v[2];
        if (idx == 0 || (idx >= 2 && idx <= 11) || (idx >= 16 && idx <= 27) || idx == 1)
            m[idx] = v;
        else if (idx == 12) begin m[12] = v; m[14] = m[14] | v; end
        else if (idx == 13) begin m[13] = v; m[14] = m[14] & ~v; end
        @(negedge clk);
        wr_en = 1'b1; addr = {idx[4:0], lo}; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
        chk(sys_reset_req == exp_p, "R6 pulse", {31'd0, sys_reset_req}, {31'd0, exp_p});
        if (exp_p) begin
            @(negedge clk);
            chk(sys_reset_req == 1'b0, "R6 one-cycle", {31'd0, sys_reset_req}, 32'd0);
        end
    endtask

    task automatic rd(input int idx, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = {idx[4:0], 2'b00};
        @(negedge clk);
        rd_en = 1'b0;
        chk(rdata == m[idx], tag, rdata, m[idx]);
    endtask

    task automatic chk_irq(input string tag);
        chk(irq_enable == m[14], {tag, " R8 enable"}, irq_enable, m[14]);
        chk(irq_edge == m[9], {tag, " R8 edge"}, irq_edge, m[9]);
        chk(irq_polarity == m[11], {tag, " R8 polarity"}, irq_polarity, m[11]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sys_reset_req == 1'b0, "R1 reset req", {31'd0, sys_reset_req}, 32'd0);
        chk_irq("R1");
        // R1 and R7: reset sweep over every index, including the undefined ones
        for (int i = 0; i < 32; i++) rd(i, (i < 28) ? "R1 reset value" : "R7 undefined read");

        // R2, R5, R7: write a distinct pattern to every index, low address bits varied
        for (int i = 0; i < 32; i++) begin
            if (i != 1) wr(i, 2'(i), 32'h1357_9BD0 ^ (32'(i) * 32'h0102_0409));
        end
        for (int i = 0; i < 32; i++) rd(i, "R2 R5 R7 sweep readback");
        chk_irq("sweep");

        // R6: clear, raise, re-raise, lower, raise again
        wr(1, 2'b00, 32'h0000_0000);
        wr(1, 2'b00, 32'h0000_0004);
        wr(1, 2'b00, 32'hFFFF_FFFF);
        rd(1, "R6 stored");
        wr(1, 2'b10, 32'hFFFF_FFFB);
        wr(1, 2'b01, 32'h0000_0004);
        rd(1, "R6 stored");

        // R3, R4, R5: overlapping set and clear patterns with direct write attempts
        for (int j = 0; j < 16; j++) begin
            wr(12, 2'b00, (32'h8000_0001 << j) | (32'(j) * 32'h0011_0101));
            chk_irq("R3 set");
            wr(14, 2'b00, 32'h0F0F_0F0F ^ 32'(j));
            chk_irq("R5 direct");
            wr(13, 2'b00, 32'h00FF_00FF >> j);
            chk_irq("R4 clear");
            wr(15, 2'b00, 32'hFFFF_FFFF);
            rd(15, "R5 status");
        end
        rd(12, "R3 stored");
        rd(13, "R4 stored");
        rd(14, "R5 enable read");

        // R9: read and write to the same word in one cycle returns old value
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = {5'd3, 2'b00}; wdata = 32'hCAFE_F00D;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rdata == m[3], "R9 read-before-write", rdata, m[3]);
        m[3] = 32'hCAFE_F00D;
        rd(3, "R9 new value");

        // R1: reset returns every register to its initial value
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 32; i++) rd(i, "R1 re-reset value");
        chk_irq("R1 re-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule